// File: doc/BRIEF.md
# Reset Cause Status and Control Register

This block holds a single 32-bit register that tells software why the system last came out of reset and lets software start a new one. Five bits at the top of the word carry meaning. The power-on cause bit and the two push-button cause bits are sticky status: hardware sets them, and software clears one by writing a one to it. The two soft-reset bits are plain read/write command bits. Writing a one to either of them produces a single-cycle system reset request.

A saturating counter records how many system resets have occurred since the last cold start. Only a reset that arrives while the counter is zero loads the register with the power-on cause alone. Later resets leave the register as it was. A soft power-on command zeroes the counter, so the reset it triggers is reported as a power-on again. A soft externally-initiated reset command leaves the counter untouched.

The register sits in the upper 32-bit word of an 8-byte aligned slot at a parameterised base address. The lower word of the slot reads zero and discards writes.

Top module: `reset_cause_reg`

## Requirements
- R1: While `cold_rst` is high, the counter, the register and `sys_rst_req` are cleared. Afterwards a read of the upper word returns 0 and no request is raised.
- R2: A system reset (`rst` high at a clock edge) that arrives while the counter is zero loads the register with 0x80000000, the power-on cause at bit 31 and nothing else.
- R3: A system reset that arrives while the counter is non-zero leaves the register unchanged. The counter increments on every system reset.
- R4: The counter saturates at its all-ones value and never wraps to zero. After any number of further resets, bit 31 is not set again.
- R5: Write data is masked to bits 31..27. Bits 26..0 always read as zero.
- R6: Bits 31 (power-on), 28 (button power-on) and 27 (button external reset) are write-one-to-clear. Writing zero to them leaves them unchanged.
- R7: Bits 30 (soft power-on) and 29 (soft external reset) take the written value, both 1 and 0.
- R8: A write with bit 30 set raises `sys_rst_req` for exactly one cycle and zeroes the counter, so the next system reset loads 0x80000000.
- R9: A write with bit 29 set and bit 30 clear raises `sys_rst_req` for exactly one cycle and leaves the counter unchanged.
- R10: Only byte offset 4 of the slot (address bit 2 set) is the register. Offset 0 and addresses outside the slot read zero, and writes to them have no effect.
- R11: A `btn_por_evt` pulse sets bit 28 and a `btn_xir_evt` pulse sets bit 27. If a write clears one of these bits in the same cycle as its event, the event wins.
- R12: A write in the same cycle as a system reset is ignored: the register is not written and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Cold start: clears the counter, the register and the request |
| rst | input | 1 | Synchronous active-high system reset, counted by the block |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` and `rd_en` |
| btn_por_evt | input | 1 | Debounced button power-on event |
| btn_xir_evt | input | 1 | Debounced button external-reset event |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
A write, a cause event or a system reset updates the register at the clock edge that samples it. A read driven in the following cycle returns the new value combinationally. `sys_rst_req` rises at the edge that samples the command write and falls at the next edge. The bench therefore changes inputs only on falling edges and has a monitor compare outputs shortly after the next falling edge. A request check pushed right after a write looks at the pulse cycle, and a second check pushed one cycle later confirms the pulse has ended. Saturation is checked only through the register value after a long run of resets, since the counter has no port of its own.

// File: rtl/reset_cause_pkg.sv
package reset_cause_pkg;

    localparam int WORD_W = 32;

    localparam int BIT_PWR_ON   = 31;
    localparam int BIT_SOFT_POR = 30;
    localparam int BIT_SOFT_XIR = 29;
    localparam int BIT_BTN_POR  = 28;
    localparam int BIT_BTN_XIR  = 27;

    localparam logic [WORD_W-1:0] LIVE_MASK  = 32'hF800_0000;
    localparam logic [WORD_W-1:0] W1C_MASK   = 32'h9800_0000;
    localparam logic [WORD_W-1:0] DIRECT_MASK = 32'h6000_0000;
    localparam logic [WORD_W-1:0] POR_VALUE  = 32'h8000_0000;

    typedef struct packed {
        logic        pwr_on;
        logic        soft_por;
        logic        soft_xir;
        logic        btn_por;
        logic        btn_xir;
        logic [26:0] unused;
    } cause_word_t;

    typedef struct packed {
        logic       hit;
        logic [WORD_W-1:0] data;
    } reg_write_t;

    function automatic logic [WORD_W-1:0] apply_write(
        input logic [WORD_W-1:0] cur,
        input logic [WORD_W-1:0] raw
    );
        logic [WORD_W-1:0] v;
        logic [WORD_W-1:0] r;
        v = raw & LIVE_MASK;
        r = cur & ~(v & W1C_MASK);
        r = (r & ~DIRECT_MASK) | (v & DIRECT_MASK);
        return r & LIVE_MASK;
    endfunction

    function automatic logic is_command(input logic [WORD_W-1:0] raw);
        return raw[BIT_SOFT_POR] | raw[BIT_SOFT_XIR];
    endfunction

endpackage

// File: rtl/rcr_decode.sv
module rcr_decode #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_hit,
    output logic              rd_hit
);
    localparam int SLOT_LSB = 3;
    localparam int WORD_SEL = 2;

    logic in_slot;
    logic upper;

    always_comb begin
        in_slot = (addr[ADDR_W-1:SLOT_LSB] == BASE_ADDR[ADDR_W-1:SLOT_LSB]);
        upper   = addr[WORD_SEL];
        wr_hit  = wr_en & in_slot & upper;
        rd_hit  = rd_en & in_slot & upper;
    end
endmodule

// File: rtl/rcr_counter.sv
module rcr_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             cold_rst,
    input  logic             rst,
    input  logic             clr,
    output logic             first,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            cnt_q <= '0;
        end else if (rst) begin
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (clr) begin
            cnt_q <= '0;
        end
    end

    assign first = (cnt_q == '0);
    assign count = cnt_q;
endmodule

// File: rtl/rcr_status.sv
module rcr_status
    import reset_cause_pkg::*;
(
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              rst,
    input  logic              first,
    input  reg_write_t        wr,
    input  logic              btn_por_evt,
    input  logic              btn_xir_evt,
    output logic [WORD_W-1:0] status,
    output logic              cnt_clr,
    output logic              req
);
    cause_word_t stat_q;
    cause_word_t stat_d;
    logic        req_q;

    always_comb begin
        logic [WORD_W-1:0] w;
        w = stat_q;
        if (wr.hit) begin
            w = apply_write(w, wr.data);
        end
        stat_d = cause_word_t'(w);
        if (btn_por_evt) stat_d.btn_por = 1'b1;
        if (btn_xir_evt) stat_d.btn_xir = 1'b1;
        stat_d.unused = '0;
    end

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            stat_q <= '0;
            req_q  <= 1'b0;
        end else if (rst) begin
            req_q <= 1'b0;
            if (first) begin
                stat_q <= cause_word_t'(POR_VALUE);
            end
        end else begin
            stat_q <= stat_d;
            req_q  <= wr.hit & is_command(wr.data);
        end
    end

    assign cnt_clr = wr.hit & wr.data[BIT_SOFT_POR] & ~rst & ~cold_rst;
    assign status  = stat_q;
    assign req     = req_q;
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
    import reset_cause_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              btn_por_evt,
    input  logic              btn_xir_evt,
    output logic              sys_rst_req
);
    logic              wr_hit;
    logic              rd_hit;
    logic              first;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_clr;
    logic [WORD_W-1:0] status;
    reg_write_t        wr;

    rcr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    assign wr.hit  = wr_hit;
    assign wr.data = wdata;

    rcr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .cold_rst (cold_rst),
        .rst      (rst),
        .clr      (cnt_clr),
        .first    (first),
        .count    (cnt)
    );

    rcr_status u_stat (
        .clk         (clk),
        .cold_rst    (cold_rst),
        .rst         (rst),
        .first       (first),
        .wr          (wr),
        .btn_por_evt (btn_por_evt),
        .btn_xir_evt (btn_xir_evt),
        .status      (status),
        .cnt_clr     (cnt_clr),
        .req         (sys_rst_req)
    );

    assign rdata = rd_hit ? status : '0;
endmodule

// File: rtl/reset_cause_reg_chk.sv
module reset_cause_reg_chk #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
    parameter int CNT_W = 4
) (
    input logic              clk,
    input logic              cold_rst,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              sys_rst_req,
    input logic [31:0]       status,
    input logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic reg_wr;
    assign reg_wr = wr_en && addr[2] &&
                    (addr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]);

    a_r2_first_load: assert property (@(posedge clk) disable iff (cold_rst)
        rst && cnt == '0 |=> status == 32'h8000_0000);

    a_r3_keep_later: assert property (@(posedge clk) disable iff (cold_rst)
        rst && cnt != '0 |=> $stable(status));

    a_r4_saturate: assert property (@(posedge clk) disable iff (cold_rst)
        rst && cnt == CMAX |=> cnt == CMAX);

    a_r5_low_bits_zero: assert property (@(posedge clk) disable iff (cold_rst)
        status[26:0] == '0);

    a_r6_w1c_pwr_on: assert property (@(posedge clk) disable iff (cold_rst)
        reg_wr && !rst && wdata[31] |=> !status[31]);

    a_r8_req_source: assert property (@(posedge clk) disable iff (cold_rst)
        sys_rst_req |-> $past(reg_wr && !rst && (wdata[30] || wdata[29])));

    a_r10_lower_zero: assert property (@(posedge clk) disable iff (cold_rst)
        rd_en && !addr[2] |-> rdata == '0);
endmodule

bind reset_cause_reg reset_cause_reg_chk #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .cold_rst    (cold_rst),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .sys_rst_req (sys_rst_req),
    .status      (status),
    .cnt         (cnt)
);

// File: tb/reset_cause_reg_test.sv
module reset_cause_reg_test;
    localparam int PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam logic [15:0] REG_A = 16'hF024;
    localparam logic [15:0] LOW_A = 16'hF020;
    localparam logic [15:0] OUT_A = 16'hF02C;

    logic        clk = 1'b0;
    logic        cold_rst = 1'b1;
    logic        rst = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        btn_por_evt = 1'b0;
    logic        btn_xir_evt = 1'b0;
    logic        sys_rst_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_req;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #(PERIOD/2) clk = ~clk;

    reset_cause_reg #(.ADDR_W(ADDR_W), .BASE_ADDR(16'hF020), .CNT_W(4)) uut (
        .clk(clk), .cold_rst(cold_rst), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .btn_por_evt(btn_por_evt),
        .btn_xir_evt(btn_xir_evt), .sys_rst_req(sys_rst_req)
    );

    // monitor: compares just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                act = it.is_req ? {31'b0, sys_rst_req} : rdata;
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic idle();
        cold_rst = 0; rst = 0; wr_en = 0; rd_en = 0;
        btn_por_evt = 0; btn_xir_evt = 0; addr = '0; wdata = '0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); idle(); wr_en = 1; addr = a; wdata = d;
    endtask

    task automatic chk_rd(input logic [15:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk); idle(); rd_en = 1; addr = a;
        it.is_req = 0; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic chk_req(input bit e, input string tag);
        item_t it;
        @(negedge clk); idle();
        it.is_req = 1; it.exp = {31'b0, e}; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic do_rst();
        @(negedge clk); idle(); rst = 1;
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: cold start state
        chk_rd(REG_A, 32'h0, "R1 after cold start");
        chk_req(0, "R1 no request");
        // R2: first system reset
        do_rst();
        chk_rd(REG_A, 32'h8000_0000, "R2 first reset loads por");
        // R5: masked bits
        wr(REG_A, 32'h07FF_FFFF);
        chk_rd(REG_A, 32'h8000_0000, "R5 low bits masked");
        // R10: lower word and outside slot
        wr(LOW_A, 32'hFFFF_FFFF);
        chk_req(0, "R10 lower write no request");
        chk_rd(LOW_A, 32'h0, "R10 lower word reads zero");
        chk_rd(REG_A, 32'h8000_0000, "R10 lower write ignored");
        wr(OUT_A, 32'hE000_0000);
        chk_req(0, "R10 outside write no request");
        chk_rd(REG_A, 32'h8000_0000, "R10 outside write ignored");
        // R6: clear power-on bit
        wr(REG_A, 32'h8000_0000);
        chk_rd(REG_A, 32'h0, "R6 por bit cleared");
        // R3: later reset keeps register
        do_rst();
        chk_rd(REG_A, 32'h0, "R3 later reset keeps value");
        // R11: button events
        @(negedge clk); idle(); btn_por_evt = 1;
        chk_rd(REG_A, 32'h1000_0000, "R11 button por sets bit 28");
        @(negedge clk); idle(); btn_xir_evt = 1;
        chk_rd(REG_A, 32'h1800_0000, "R11 button xir sets bit 27");
        wr(REG_A, 32'h0000_0000);
        chk_rd(REG_A, 32'h1800_0000, "R6 writing zero keeps sticky bits");
        wr(REG_A, 32'h0800_0000);
        chk_rd(REG_A, 32'h1000_0000, "R6 bit 27 cleared");
        @(negedge clk); idle(); wr_en = 1; addr = REG_A; wdata = 32'h1000_0000; btn_por_evt = 1;
        chk_rd(REG_A, 32'h1000_0000, "R11 event wins over clear");
        wr(REG_A, 32'h1000_0000);
        chk_rd(REG_A, 32'h0, "R6 bit 28 cleared");
        // R9: soft external reset command
        wr(REG_A, 32'h2000_0000);
        chk_req(1, "R9 request pulse");
        chk_req(0, "R9 pulse single cycle");
        chk_rd(REG_A, 32'h2000_0000, "R7 bit 29 set");
        wr(REG_A, 32'h0);
        chk_req(0, "R7 zero write no request");
        chk_rd(REG_A, 32'h0, "R7 bit 29 written zero");
        do_rst();
        chk_rd(REG_A, 32'h0, "R9 counter kept, no por load");
        // R4: saturation
        for (int i = 0; i < 20; i++) do_rst();
        chk_rd(REG_A, 32'h0, "R4 counter does not wrap");
        // R12: write during reset ignored
        @(negedge clk); idle(); rst = 1; wr_en = 1; addr = REG_A; wdata = 32'h4000_0000;
        chk_req(0, "R12 no request during reset");
        chk_rd(REG_A, 32'h0, "R12 write ignored during reset");
        // R8: soft power-on command
        wr(REG_A, 32'h4000_0000);
        chk_req(1, "R8 request pulse");
        chk_req(0, "R8 pulse single cycle");
        chk_rd(REG_A, 32'h4000_0000, "R7 bit 30 set");
        do_rst();
        chk_rd(REG_A, 32'h8000_0000, "R8 counter zeroed, por reloaded");
        wr(REG_A, 32'h6000_0000);
        chk_req(1, "R8 both commands pulse");
        chk_rd(REG_A, 32'hE000_0000, "R7 both command bits set");
        // R1: cold start again
        @(negedge clk); idle(); cold_rst = 1;
        chk_rd(REG_A, 32'h0, "R1 cold clears register");
        do_rst();
        chk_rd(REG_A, 32'h8000_0000, "R1 counter cleared by cold start");
        @(negedge clk); idle();
        @(negedge clk); idle();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule